// File: doc/BRIEF.md
# Two-phase pseudo-random and deterministic BIST pattern source

The block drives every input of a small combinational circuit-under-test with one complete pattern per clock and folds the circuit's response into a multi-input signature register in the same cycle. A single linear feedback shift register supplies all patterns. After a start pulse the register's raw states go straight to the circuit for a programmable number of cycles. The states that follow then pass through a fixed output decoder, which turns them into precomputed deterministic vectors, for a second programmable number of cycles.

Most decoder outputs are plain wires to a register bit or to its complement. A few outputs are small two-level functions of register bits. Each output's source is chosen by parameters. Because the circuit-under-test is combinational, the order of the patterns does not matter. The decoder therefore only has to be right on the states that occur in the deterministic phase, and its value on every other state is irrelevant.

A phase controller switches the source multiplexers. At the end of the run it raises a done flag, the register and the signature freeze, and the final signature is read from the outputs.

Top module: `mm_bist_gen`

## Requirements
- R1: While reset is asserted and until the first start pulse, mode_o and done_o are 0, signature_o is 0 and pattern_o shows the seed 5'b00001.
- R2: A start pulse, given in any phase, reloads the seed, clears the signature and begins the pseudo-random phase on the next cycle. This also applies part-way through a run.
- R3: For PR_CYCLES cycles after start, mode_o is 0 and pattern_o is the raw register state. The first state is the seed, and each later state is x' = {x[3:0], x[4]^x[2]}.
- R4: The pattern register never holds the all-zero state.
- R5: For the DET_CYCLES cycles that follow, mode_o is 1 and pattern_o is the decoded form of the register states that continue the same sequence.
- R6: The default decoder gives pattern bit i = y_i, with y0 = x0, y1 = x1, y2 = NOT x2, y3 = x1 and y4 = (NOT x0) OR x1.
- R7: In every cycle of either phase, the signature updates as s' = {s[3:0], s[4]^s[2]} XOR resp_i, which gives PR_CYCLES+DET_CYCLES updates per run.
- R8: After the deterministic phase, done_o is 1 and mode_o is 0. The register state (seen raw on pattern_o) and the signature then hold until the next start pulse.
- R9: mode_o and done_o are never both 1. While idle, nothing advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous start and restart pulse |
| resp_i | input | RESP_W | Response of the circuit-under-test to pattern_o |
| pattern_o | output | W | Pattern applied to the circuit-under-test |
| mode_o | output | 1 | 1 during the deterministic phase |
| done_o | output | 1 | 1 once the run is complete |
| signature_o | output | RESP_W | Signature register contents |

## Verification
The checker watches every cycle for the following:
- mode_o and done_o are never high together.
- The pattern register is never zero.
- A start pulse always restores the seed and clears the signature.
- pattern_o equals the raw register outside the deterministic phase.
- The state and the signature stay frozen while done_o is high.

Some behaviour can only be shown by the bench's runs: the exact pattern sequence, the decoder equations on the states that actually occur, the phase lengths and the final signature against a model circuit. The bench covers three cases: complete runs, a restart part-way through the pseudo-random phase, and a restart part-way through the deterministic phase.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_RAND, PH_DET, PH_DONE} phase_e;
  // decoder output source kinds
  localparam logic [1:0] SRC_WIRE = 2'd0;
  localparam logic [1:0] SRC_INV  = 2'd1;
  localparam logic [1:0] SRC_SOP  = 2'd2;  // (~x[a]) | x[b]
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] TAPS = 5'b10100,
  parameter logic [W-1:0] SEED = 5'b00001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (load_i) q <= SEED;
    else if (step_i) q <= {q[W-2:0], ^(q & TAPS)};
  end
  assign state_o = q;
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] TAPS = 5'b10100
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (clear_i) q <= '0;
    else if (step_i)  q <= {q[W-2:0], ^(q & TAPS)} ^ data_i;
  end
  assign sig_o = q;
endmodule

// File: rtl/bist_phase_ctrl.sv
module bist_phase_ctrl
  import bist_pkg::*;
#(
  parameter int unsigned PR_CYCLES  = 5,
  parameter int unsigned DET_CYCLES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic step_o,
  output logic mode_o,
  output logic done_o
);
  localparam int unsigned MAXC = (PR_CYCLES > DET_CYCLES) ? PR_CYCLES : DET_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PR_LAST  = CW'(PR_CYCLES - 1);
  localparam logic [CW-1:0] DET_LAST = CW'(DET_CYCLES - 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (start_i) begin
      ph_q  <= PH_RAND;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_RAND: begin
          if (cnt_q == PR_LAST) begin
            ph_q  <= PH_DET;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_DET: begin
          if (cnt_q == DET_LAST) begin
            ph_q  <= PH_DONE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign step_o = !start_i && (ph_q == PH_RAND || ph_q == PH_DET);
  assign mode_o = (ph_q == PH_DET);
  assign done_o = (ph_q == PH_DONE);
endmodule

// File: rtl/bist_decoder.sv
module bist_decoder
  import bist_pkg::*;
#(
  parameter int unsigned W = 5,
  parameter logic [2*W-1:0] KIND  = 10'b10_00_01_00_00,
  parameter logic [8*W-1:0] SRC_A = {8'd0, 8'd1, 8'd2, 8'd1, 8'd0},
  parameter logic [8*W-1:0] SRC_B = {8'd1, 8'd0, 8'd0, 8'd0, 8'd0}
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_out
    localparam logic [1:0] K = KIND[2*i +: 2];
    localparam int unsigned A = int'(SRC_A[8*i +: 8]);
    localparam int unsigned B = int'(SRC_B[8*i +: 8]);
    if (K == SRC_WIRE) begin : g_wire
      assign y_o[i] = x_i[A];
    end else if (K == SRC_INV) begin : g_inv
      assign y_o[i] = ~x_i[A];
    end else begin : g_sop
      assign y_o[i] = ~x_i[A] | x_i[B];
    end
  end
endmodule

// File: rtl/mm_bist_gen.sv
module mm_bist_gen #(
  parameter int unsigned W          = 5,
  parameter int unsigned RESP_W     = 5,
  parameter int unsigned PR_CYCLES  = 5,
  parameter int unsigned DET_CYCLES = 5,
  parameter logic [W-1:0]      LFSR_TAPS = 5'b10100,
  parameter logic [W-1:0]      SEED      = 5'b00001,
  parameter logic [RESP_W-1:0] MISR_TAPS = 5'b10100,
  parameter logic [2*W-1:0]    DEC_KIND  = 10'b10_00_01_00_00,
  parameter logic [8*W-1:0]    DEC_SRC_A = {8'd0, 8'd1, 8'd2, 8'd1, 8'd0},
  parameter logic [8*W-1:0]    DEC_SRC_B = {8'd1, 8'd0, 8'd0, 8'd0, 8'd0}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RESP_W-1:0] resp_i,
  output logic [W-1:0]      pattern_o,
  output logic              mode_o,
  output logic              done_o,
  output logic [RESP_W-1:0] signature_o
);
  logic         step;
  logic [W-1:0] lfsr_q;
  logic [W-1:0] dec_y;

  bist_phase_ctrl #(.PR_CYCLES(PR_CYCLES), .DET_CYCLES(DET_CYCLES)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .step_o(step), .mode_o, .done_o
  );

  bist_lfsr #(.W(W), .TAPS(LFSR_TAPS), .SEED(SEED)) i_lfsr (
    .clk_i, .rst_ni, .load_i(start_i), .step_i(step), .state_o(lfsr_q)
  );

  bist_decoder #(.W(W), .KIND(DEC_KIND), .SRC_A(DEC_SRC_A), .SRC_B(DEC_SRC_B)) i_dec (
    .x_i(lfsr_q), .y_o(dec_y)
  );

  assign pattern_o = mode_o ? dec_y : lfsr_q;

  bist_misr #(.W(RESP_W), .TAPS(MISR_TAPS)) i_misr (
    .clk_i, .rst_ni, .clear_i(start_i), .step_i(step), .data_i(resp_i), .sig_o(signature_o)
  );
endmodule

// File: rtl/mm_bist_gen_chk.sv
module mm_bist_gen_chk #(
  parameter int unsigned W      = 5,
  parameter int unsigned RESP_W = 5,
  parameter logic [W-1:0] SEED  = 5'b00001
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mode_o,
  input logic              done_o,
  input logic [W-1:0]      pattern_o,
  input logic [W-1:0]      lfsr_q,
  input logic [RESP_W-1:0] signature_o
);
  // R9
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_o && done_o));
  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  // R2
  start_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (lfsr_q == SEED && signature_o == '0 && !mode_o && !done_o));
  // R3
  raw_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o |-> pattern_o == lfsr_q);
  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(lfsr_q) && $stable(signature_o)));
  // R8
  det_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mode_o) |-> (done_o || $past(start_i)));
endmodule

bind mm_bist_gen mm_bist_gen_chk #(.W(W), .RESP_W(RESP_W), .SEED(SEED)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_o(mode_o),
  .done_o(done_o), .pattern_o(pattern_o), .lfsr_q(lfsr_q), .signature_o(signature_o)
);

// File: tb/test_mm_bist_gen.sv
module test_mm_bist_gen;
  localparam int PR  = 5;
  localparam int DET = 5;
  localparam logic [4:0] SEED = 5'b00001;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start = 1'b0;
  logic [4:0] resp, pattern, sig;
  logic       mode, done;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  mm_bist_gen i_mm_bist_gen (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .resp_i(resp),
    .pattern_o(pattern), .mode_o(mode), .done_o(done), .signature_o(sig)
  );

  function automatic logic [4:0] nxt(input logic [4:0] x);
    return {x[3:0], x[4] ^ x[2]};
  endfunction
  function automatic logic [4:0] dec(input logic [4:0] x);
    return {~x[0] | x[1], x[1], ~x[2], x[1], x[0]};
  endfunction
  function automatic logic [4:0] cut(input logic [4:0] p);
    return {p[0] ^ p[4], p[1] & p[2], p[3] | p[0], ~p[2], p[4] ^ p[1]};
  endfunction
  function automatic logic [4:0] misr(input logic [4:0] s, input logic [4:0] r);
    return {s[3:0], s[4] ^ s[2]} ^ r;
  endfunction

  assign resp = cut(pattern);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // abort_at < PR+DET: return at that cycle so the next run restarts mid-way
  task automatic run(input int abort_at);
    logic [4:0] x, s;
    x = SEED;
    s = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < PR + DET; k++) begin
      if (k == abort_at) return;
      check(k < PR ? "R3 mode" : "R5 mode", 32'(mode), 32'(k >= PR));
      check("R9 done", 32'(done), 32'd0);
      if (k < PR) check("R3 pattern", 32'(pattern), 32'(x));
      else        check("R6 pattern", 32'(pattern), 32'(dec(x)));
      check(k == 0 ? "R2 signature" : "R7 signature", 32'(sig), 32'(s));
      check("R4 nonzero", 32'(pattern == 5'd0 && k < PR), 32'd0);
      s = misr(s, cut(k < PR ? x : dec(x)));
      x = nxt(x);
      @(negedge clk);
    end
    for (int h = 0; h < 3; h++) begin
      check("R8 done", 32'(done), 32'd1);
      check("R8 mode", 32'(mode), 32'd0);
      check("R8 signature", 32'(sig), 32'(s));
      check("R8 state", 32'(pattern), 32'(x));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    check("R1 mode", 32'(mode), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 signature", 32'(sig), 32'd0);
    check("R1 pattern", 32'(pattern), 32'(SEED));
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 idle pattern", 32'(pattern), 32'(SEED));
      check("R9 idle signature", 32'(sig), 32'd0);
      check("R9 idle mode", 32'(mode | done), 32'd0);
    end
    run(PR + DET);        // full run
    run(3);               // restart inside pseudo-random phase (R2)
    run(PR + 2);          // restart inside deterministic phase (R2)
    run(PR + DET);        // full run after restarts
    run(PR + DET);        // restart from done
    finish_run();
  end
endmodule